// File: doc/BRIEF.md
# Block-Cipher Accelerator Control and Status Registers

This block is the software-facing control slice of a block-cipher accelerator. A host writes 32-bit words over a simple register bus (write enable, word address, write data, combinational read data) to pick the cipher mode, key size, direction, channel, DMA and cascade options, and to issue start, stop and last-block commands. The block turns those commands into one-cycle pulses toward the cipher engine and presents the latched settings on dedicated outputs. A done pulse from the engine ends an operation.

While an operation is running, the settings are held steady and writes to them are dropped. The block also keeps the per-channel byte counts and key words. Key words can be hidden from reads by a protection flag. Once set, that flag is released only by a dedicated 5-bit unlock code, and the release also erases every stored key word. A sticky flag reports a start that was issued in DMA mode with a byte count that cannot be processed in whole 16-byte blocks.

Top module: `cipher_ctl_regs`

## Requirements
- R1: Bit 0 of the control word (address 0x00) is a write-one start command. When the block is idle, and stop is not written in the same word, it sets `busy` and raises `eng_start` for exactly one cycle after the write. A start written while busy is dropped. Bit 0 always reads as 0.
- R2: Bit 1 of the control word is a write-one stop command. It raises `eng_stop` for one cycle and clears `busy`. When start and stop are written together, stop wins and no start pulse is issued. Bit 1 always reads as 0.
- R3: A one-cycle `eng_done` pulse while busy clears `busy` on the next clock edge.
- R4: Each control write with bit 5 set raises `eng_last` for one cycle. Bit 5 always reads as 0.
- R5: The settings fields are key size (bits 3:2), cascade (bit 6), DMA enable (bit 7), mode (bits 15:8), encrypt (bit 16, 1 = encrypt, 0 = decrypt) and channel (bits 25:24). They are loaded by a control write while idle, read back at these positions, and drive the matching `eng_*` outputs. Control writes while busy leave all of them unchanged.
- R6: A control write with bit 31 set turns on key protection. Bit 31 of the control word reads back as the protection flag. While protection is on, every key-word read returns 0.
- R7: A control write made while idle, with bit 31 = 0 and bits 30:26 = 10110, clears protection and sets every key word of every channel to 0. Any other code, or any write while busy, leaves protection as it is. Bits 30:26 read back the last code written while idle.
- R8: The count error flag sets when a start is accepted with DMA enabled, a mode of 0x00–0x04 (ECB 0x00, CBC 0x01, CFB 0x02, OFB 0x03, CTR 0x04), and a byte count for the selected channel that is 0 or not a multiple of 16. It does not set for the stealing modes 0x10–0x12, and it does not set with DMA disabled.
- R9: The status word (address 0x01) reads `busy` in bit 0 and the count error in bit 12, with all other bits 0. Writing 1 to bit 12 clears the count error. Writing 0 to bit 12 leaves it set.
- R10: The address map is: byte count of channel c at 0x04+c; key word k of channel c at 0x20+8c+k. Both are read-write. Unmapped addresses read 0 and ignore writes.
- R11: After reset, every register, flag and engine output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_stop | output | 1 | One-cycle stop pulse to the engine |
| eng_last | output | 1 | One-cycle last-block pulse to the engine |
| eng_keysz | output | 2 | Latched key size |
| eng_cascade | output | 1 | Latched cascade enable |
| eng_dma | output | 1 | Latched DMA enable |
| eng_mode | output | 8 | Latched cipher mode code |
| eng_encrypt | output | 1 | Latched direction, 1 = encrypt |
| eng_chan | output | 2 | Latched channel select |
| eng_done | input | 1 | Completion pulse from the engine |
| busy | output | 1 | Operation in progress |
| cnt_err | output | 1 | Sticky byte-count error |

## Verification
The hardest situation to reach is an unlock code that arrives while an operation is running. To get there, protection must already be set, a start must have been accepted, and the engine must not yet have signalled done. The bench first sets protection, then issues a start with DMA off and holds back `eng_done`. With the engine still busy, it writes the correct code and checks that the protection flag and the key contents are unchanged. It then ends the operation and repeats the same code to confirm the key wipe. The count error is driven along each axis separately (non-multiple count, zero count, stealing mode, DMA off), so that each qualifying condition is shown to matter on its own.

// File: rtl/cc_pkg.sv
package cc_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [7:0] {
      MODE_ECB = 8'h00,
      MODE_CBC = 8'h01,
      MODE_CFB = 8'h02,
      MODE_OFB = 8'h03,
      MODE_CTR = 8'h04,
      MODE_CS1 = 8'h10,
      MODE_CS2 = 8'h11,
      MODE_CS3 = 8'h12
   } cc_mode_e;

   typedef struct packed {
      logic [1:0] keysz;
      logic       cascade;
      logic       dma;
      logic [7:0] mode;
      logic       encrypt;
      logic [1:0] chan;
      logic [4:0] unlock;
   } cc_cfg_t;

   // Modes that demand whole 16-byte blocks in DMA transfers
   function automatic logic whole_block_mode(input logic [7:0] m);
      return (m <= 8'(MODE_CTR));
   endfunction

endpackage

// File: rtl/cc_ctrl_reg.sv
module cc_ctrl_reg
   import cc_pkg::*;
#(
   parameter logic [4:0] UNLOCK_CODE = 5'b10110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [WORD_W-1:0] wdata,
   input  logic              done,
   output cc_cfg_t           cfg,
   output logic              busy,
   output logic              prot,
   output logic              start_p,
   output logic              stop_p,
   output logic              last_p,
   output logic              start_acc,
   output logic              wipe
);

   logic start_req, stop_req, cfg_we, unlock_hit;
   logic unused_bits;

   assign unused_bits = ^{wdata[4], wdata[23:17]};
   assign start_req   = wr_ctrl & wdata[0];
   assign stop_req    = wr_ctrl & wdata[1];
   assign start_acc   = start_req & ~stop_req & ~busy;
   assign cfg_we      = wr_ctrl & ~busy;
   assign unlock_hit  = cfg_we & ~wdata[31] & (wdata[30:26] == UNLOCK_CODE);
   assign wipe        = unlock_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         busy    <= 1'b0;
         prot    <= 1'b0;
         start_p <= 1'b0;
         stop_p  <= 1'b0;
         last_p  <= 1'b0;
      end else begin
         if (cfg_we) begin
            cfg.keysz   <= wdata[3:2];
            cfg.cascade <= wdata[6];
            cfg.dma     <= wdata[7];
            cfg.mode    <= wdata[15:8];
            cfg.encrypt <= wdata[16];
            cfg.chan    <= wdata[25:24];
            cfg.unlock  <= wdata[30:26];
         end
         if (stop_req)       busy <= 1'b0;
         else if (start_acc) busy <= 1'b1;
         else if (done)      busy <= 1'b0;
         if (wr_ctrl && wdata[31]) prot <= 1'b1;
         else if (unlock_hit)      prot <= 1'b0;
         start_p <= start_acc;
         stop_p  <= stop_req;
         last_p  <= wr_ctrl & wdata[5];
      end
   end

endmodule

// File: rtl/cc_count_bank.sv
module cc_count_bank
   import cc_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [WORD_W-1:0] wdata,
   input  logic [CH_W-1:0]   rd_ch,
   output logic [WORD_W-1:0] rd_count,
   input  logic              chk,
   input  logic              chk_dma,
   input  logic [7:0]        chk_mode,
   input  logic [CH_W-1:0]   chk_ch,
   input  logic              clr,
   output logic              err
);

   logic [WORD_W-1:0] cnt_q [NUM_CH];
   logic [WORD_W-1:0] sel_cnt;
   logic              bad_len, err_set;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                cnt_q[c] <= '0;
         else if (wr_en && wr_ch == CH_W'(c))       cnt_q[c] <= wdata;
      end
   end

   assign rd_count = cnt_q[rd_ch];
   assign sel_cnt  = cnt_q[chk_ch];
   assign bad_len  = (sel_cnt == '0) | (sel_cnt[3:0] != 4'h0);
   assign err_set  = chk & chk_dma & whole_block_mode(chk_mode) & bad_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err <= 1'b0;
      else if (err_set) err <= 1'b1;
      else if (clr)     err <= 1'b0;
   end

endmodule

// File: rtl/cc_key_bank.sv
module cc_key_bank
   import cc_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int KEY_WORDS = 8,
   localparam int ENTRIES  = NUM_CH * KEY_WORDS,
   localparam int KIDX_W   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [KIDX_W-1:0] wr_idx,
   input  logic [WORD_W-1:0] wdata,
   input  logic              wipe,
   input  logic              hide,
   input  logic [KIDX_W-1:0] rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] key_q [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               key_q[g] <= '0;
         else if (wipe)                            key_q[g] <= '0;
         else if (wr_en && wr_idx == KIDX_W'(g))   key_q[g] <= wdata;
      end
   end

   assign rd_data = hide ? '0 : key_q[rd_idx];

endmodule

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs
   import cc_pkg::*;
#(
   parameter int         ADDR_W      = 7,
   parameter int         NUM_CH      = 4,
   parameter int         KEY_WORDS   = 8,
   parameter int         CNT_BASE    = 4,
   parameter int         KEY_BASE    = 32,
   parameter logic [4:0] UNLOCK_CODE = 5'b10110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wen,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              eng_start,
   output logic              eng_stop,
   output logic              eng_last,
   output logic [1:0]        eng_keysz,
   output logic              eng_cascade,
   output logic              eng_dma,
   output logic [7:0]        eng_mode,
   output logic              eng_encrypt,
   output logic [1:0]        eng_chan,
   input  logic              eng_done,
   output logic              busy,
   output logic              cnt_err
);

   localparam int CH_W    = $clog2(NUM_CH);
   localparam int ENTRIES = NUM_CH * KEY_WORDS;
   localparam int KIDX_W  = $clog2(ENTRIES);
   localparam logic [ADDR_W-1:0] A_CTRL     = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_STAT     = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CNT      = ADDR_W'(CNT_BASE);
   localparam logic [ADDR_W-1:0] A_CNT_END  = ADDR_W'(CNT_BASE + NUM_CH - 1);
   localparam logic [ADDR_W-1:0] A_KEY      = ADDR_W'(KEY_BASE);
   localparam logic [ADDR_W-1:0] A_KEY_END  = ADDR_W'(KEY_BASE + ENTRIES - 1);

   if (NUM_CH < 2 || NUM_CH > 4 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be 2 or 4");
   end
   if (KEY_WORDS < 4 || KEY_WORDS > 8) begin : g_bad_kw
      $error("KEY_WORDS must lie in 4..8");
   end
   if (CNT_BASE < 2 || CNT_BASE + NUM_CH > KEY_BASE) begin : g_bad_map
      $error("count window overlaps another window");
   end
   if (KEY_BASE + ENTRIES > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too narrow for the key window");
   end

   cc_cfg_t           cfg;
   logic              prot_q, start_acc, wipe;
   logic              wr_ctrl, wr_stat, is_cnt, is_key;
   logic [ADDR_W-1:0] cnt_off, key_off;
   logic [31:0]       cnt_rd, key_rd, ctrl_rd, stat_rd;

   assign is_cnt  = (bus_addr >= A_CNT) && (bus_addr <= A_CNT_END);
   assign is_key  = (bus_addr >= A_KEY) && (bus_addr <= A_KEY_END);
   assign cnt_off = bus_addr - A_CNT;
   assign key_off = bus_addr - A_KEY;
   assign wr_ctrl = bus_wen && (bus_addr == A_CTRL);
   assign wr_stat = bus_wen && (bus_addr == A_STAT);

   cc_ctrl_reg #(.UNLOCK_CODE(UNLOCK_CODE)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
      .done(eng_done), .cfg(cfg), .busy(busy), .prot(prot_q),
      .start_p(eng_start), .stop_p(eng_stop), .last_p(eng_last),
      .start_acc(start_acc), .wipe(wipe)
   );

   cc_count_bank #(.NUM_CH(NUM_CH)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && is_cnt),
      .wr_ch(cnt_off[CH_W-1:0]), .wdata(bus_wdata),
      .rd_ch(cnt_off[CH_W-1:0]), .rd_count(cnt_rd),
      .chk(start_acc), .chk_dma(bus_wdata[7]), .chk_mode(bus_wdata[15:8]),
      .chk_ch(bus_wdata[24 +: CH_W]), .clr(wr_stat && bus_wdata[12]),
      .err(cnt_err)
   );

   cc_key_bank #(.NUM_CH(NUM_CH), .KEY_WORDS(KEY_WORDS)) u_key (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wen && is_key),
      .wr_idx(key_off[KIDX_W-1:0]), .wdata(bus_wdata), .wipe(wipe),
      .hide(prot_q), .rd_idx(key_off[KIDX_W-1:0]), .rd_data(key_rd)
   );

   assign eng_keysz   = cfg.keysz;
   assign eng_cascade = cfg.cascade;
   assign eng_dma     = cfg.dma;
   assign eng_mode    = cfg.mode;
   assign eng_encrypt = cfg.encrypt;
   assign eng_chan    = cfg.chan;

   always_comb begin
      ctrl_rd        = '0;
      ctrl_rd[31]    = prot_q;
      ctrl_rd[30:26] = cfg.unlock;
      ctrl_rd[25:24] = cfg.chan;
      ctrl_rd[16]    = cfg.encrypt;
      ctrl_rd[15:8]  = cfg.mode;
      ctrl_rd[7]     = cfg.dma;
      ctrl_rd[6]     = cfg.cascade;
      ctrl_rd[3:2]   = cfg.keysz;
      stat_rd        = '0;
      stat_rd[12]    = cnt_err;
      stat_rd[0]     = busy;
   end

   always_comb begin
      if (bus_addr == A_CTRL)      bus_rdata = ctrl_rd;
      else if (bus_addr == A_STAT) bus_rdata = stat_rd;
      else if (is_cnt)             bus_rdata = cnt_rd;
      else if (is_key)             bus_rdata = key_rd;
      else                         bus_rdata = '0;
   end

endmodule

// File: rtl/cc_chk.sv
module cc_chk #(
   parameter int         ADDR_W      = 7,
   parameter logic [4:0] UNLOCK_CODE = 5'b10110
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wen,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              busy,
   input logic              cnt_err,
   input logic              eng_start,
   input logic              eng_stop,
   input logic              eng_done,
   input logic [1:0]        eng_keysz,
   input logic [7:0]        eng_mode,
   input logic              prot
);

   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && bus_addr == '0 && bus_wdata[0] && !bus_wdata[1] && !busy) |=> (busy && eng_start)); // R1
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start); // R1
   AST_STOP_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_stop |-> !busy); // R2
   AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done) |=> !busy); // R3
   AST_SETTINGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(eng_keysz) && $stable(eng_mode))); // R5
   AST_UNLOCK_BY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot) |-> $past(bus_wen && bus_addr == '0 && !bus_wdata[31]
                            && bus_wdata[30:26] == UNLOCK_CODE && !busy)); // R7
   AST_ERR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_err) |-> eng_start); // R8

endmodule

bind cipher_ctl_regs cc_chk #(.ADDR_W(ADDR_W), .UNLOCK_CODE(UNLOCK_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .busy(busy), .cnt_err(cnt_err),
   .eng_start(eng_start), .eng_stop(eng_stop), .eng_done(eng_done),
   .eng_keysz(eng_keysz), .eng_mode(eng_mode), .prot(prot_q)
);

// File: tb/sim_cipher_ctl_regs.sv
`timescale 1ns/1ps
module sim_cipher_ctl_regs;

   localparam int AW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wen = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          eng_start, eng_stop, eng_last, eng_cascade, eng_dma, eng_encrypt;
   logic [1:0]    eng_keysz, eng_chan;
   logic [7:0]    eng_mode;
   logic          eng_done = 1'b0;
   logic          busy, cnt_err;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cipher_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
      .eng_stop(eng_stop), .eng_last(eng_last), .eng_keysz(eng_keysz),
      .eng_cascade(eng_cascade), .eng_dma(eng_dma), .eng_mode(eng_mode),
      .eng_encrypt(eng_encrypt), .eng_chan(eng_chan), .eng_done(eng_done),
      .busy(busy), .cnt_err(cnt_err)
   );

   // {write address, write data, read address, expected read data}
   localparam int NV = 10;
   localparam logic [77:0] VEC [NV] = '{
      {7'h00, 32'h0601_044C, 7'h00, 32'h0601_044C},  // R5 fields, harmless code
      {7'h00, 32'h0000_0022, 7'h00, 32'h0000_0000},  // R2 R4 pulses read 0
      {7'h04, 32'h0000_0040, 7'h04, 32'h0000_0040},  // R10 count ch0
      {7'h07, 32'h0000_0123, 7'h07, 32'h0000_0123},  // R10 count ch3
      {7'h2D, 32'hDEAD_BEEF, 7'h2D, 32'hDEAD_BEEF},  // R10 key ch1 w5
      {7'h3F, 32'h1234_5678, 7'h3F, 32'h1234_5678},  // R10 key ch3 w7
      {7'h01, 32'h0000_1000, 7'h01, 32'h0000_0000},  // R9 status idle
      {7'h10, 32'hFFFF_FFFF, 7'h10, 32'h0000_0000},  // R10 unmapped
      {7'h40, 32'hFFFF_FFFF, 7'h40, 32'h0000_0000},  // R10 past key window
      {7'h00, 32'h0000_0300, 7'h00, 32'h0000_0300}   // R5 mode OFB
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      // R11 reset state
      rd(7'h00, r); check("R11 ctrl", r, 32'h0);
      rd(7'h01, r); check("R11 status", r, 32'h0);
      rd(7'h2D, r); check("R11 key", r, 32'h0);
      check("R11 outputs", {24'h0, eng_start, eng_stop, eng_last, busy, cnt_err, eng_dma, eng_keysz}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][77:71], VEC[i][70:39]);
         rd(VEC[i][38:32], r);
         check($sformatf("R10/R5 vector %0d", i), r, VEC[i][31:0]);
      end

      // R1 start with DMA, ECB, ch0 count 0x40 (valid)
      wr(7'h00, 32'h0000_0081);
      check("R1 start pulse", {31'h0, eng_start}, 32'h1);
      check("R1 busy", {31'h0, busy}, 32'h1);
      check("R8 valid count no err", {31'h0, cnt_err}, 32'h0);
      @(negedge clk);
      check("R1 pulse width", {31'h0, eng_start}, 32'h0);
      rd(7'h01, r); check("R9 status busy", r, 32'h1);
      // R5 frozen while busy, R1 start while busy dropped
      wr(7'h00, 32'h0000_000D);
      check("R1 no start when busy", {31'h0, eng_start}, 32'h0);
      check("R5 keysz frozen", {30'h0, eng_keysz}, 32'h0);
      rd(7'h00, r); check("R5 ctrl frozen", r, 32'h0000_0080);
      // R3 done clears busy
      done_pulse();
      check("R3 done clears busy", {31'h0, busy}, 32'h0);
      // R4 last pulse
      wr(7'h00, 32'h0000_0020);
      check("R4 last pulse", {31'h0, eng_last}, 32'h1);
      @(negedge clk);
      check("R4 last width", {31'h0, eng_last}, 32'h0);
      // R2 stop
      wr(7'h00, 32'h0000_0001);
      wr(7'h00, 32'h0000_0002);
      check("R2 stop pulse", {31'h0, eng_stop}, 32'h1);
      check("R2 stop clears busy", {31'h0, busy}, 32'h0);
      wr(7'h00, 32'h0000_0003);
      check("R2 stop wins", {29'h0, eng_start, eng_stop, busy}, 32'h2);

      // R8 count error: ch1 count 24
      wr(7'h05, 32'h0000_0018);
      wr(7'h00, 32'h0100_0081);
      check("R8 non-multiple", {31'h0, cnt_err}, 32'h1);
      rd(7'h01, r); check("R9 status err+busy", r, 32'h0000_1001);
      done_pulse();
      wr(7'h01, 32'h0000_0001);
      rd(7'h01, r); check("R9 write 0 keeps err", r, 32'h0000_1000);
      wr(7'h01, 32'h0000_1000);
      rd(7'h01, r); check("R9 w1c clears", r, 32'h0);
      wr(7'h00, 32'h0100_1081);
      check("R8 stealing mode no err", {31'h0, cnt_err}, 32'h0);
      done_pulse();
      wr(7'h00, 32'h0100_0001);
      check("R8 dma off no err", {31'h0, cnt_err}, 32'h0);
      done_pulse();
      wr(7'h00, 32'h0200_0281);
      check("R8 zero count", {31'h0, cnt_err}, 32'h1);
      done_pulse();
      wr(7'h01, 32'h0000_1000);

      // R6 protection
      wr(7'h00, 32'h8000_0000);
      rd(7'h00, r); check("R6 prot flag", r, 32'h8000_0000);
      rd(7'h2D, r); check("R6 key hidden", r, 32'h0);
      // R7 wrong code
      wr(7'h00, 32'h2800_0000);
      rd(7'h00, r); check("R7 wrong code", r, 32'hA800_0000);
      // R7 right code while busy
      wr(7'h00, 32'h0000_0001);
      wr(7'h00, 32'h5800_0000);
      rd(7'h00, r); check("R7 busy unlock ignored", r, 32'h8000_0000);
      done_pulse();
      wr(7'h00, 32'h5800_0000);
      rd(7'h00, r); check("R7 unlock", r, 32'h5800_0000);
      rd(7'h2D, r); check("R7 key wiped ch1", r, 32'h0);
      rd(7'h3F, r); check("R7 key wiped ch3", r, 32'h0);
      wr(7'h22, 32'hA5A5_0F0F);
      rd(7'h22, r); check("R10 key after unlock", r, 32'hA5A5_0F0F);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule